// File: doc/BRIEF.md
# Reconfigurable Broadcast Scan Distributor

This block feeds eight internal scan-chain inputs from four external scan-in pins. Each chain takes its bit from one pin, and several chains can share a pin, so one external stream loads many chains at once. The block stores two fixed chain-to-pin partitions. A select input chooses which partition should be used.

A mode input sets the switching policy. In static mode the partition in force changes only on a pattern-start strobe. A select change made in the middle of a pattern waits until the next strobe. In dynamic mode the partition may change on any shift cycle. A registered output reports the partition in force. The chain-input bus is registered and advances only while shift enable is high.

Top module: `bscan_fanout_top`

## Requirements
- R1: During reset and on the first cycle after it, `chain_si_o` is all zero and `part_active_o` is 0 (partition A).
- R2: With partition A (code 0) in use for a shift, chain index c (0-based, bit c of `chain_si_o`) takes pin `scan_pin_i[p]` as follows. Pin 0 feeds chains 1, 2 and 5. Pin 1 feeds chain 6. Pin 2 feeds chains 4 and 7. Pin 3 feeds chains 0 and 3.
- R3: With partition B (code 1) in use for a shift, pin 0 feeds chains 0 and 5, pin 1 feeds chains 1 and 3, and pin 2 feeds chains 2, 4, 6 and 7. Pin 3 has no effect on any chain.
- R4: In static mode (`dyn_mode_i`=0), a change of `cfg_sel_i` without a `pat_start_i` strobe leaves `part_active_o` and the mapping in use unchanged.
- R5: In static mode, a strobe on `pat_start_i` applies `cfg_sel_i` at once. The shift in the strobe cycle already uses the new partition, and `part_active_o` shows it one cycle later.
- R6: In dynamic mode, on any cycle with `shift_en_i` or `pat_start_i` high, `cfg_sel_i` selects the partition for that cycle's shift, and `part_active_o` shows it one cycle later.
- R7: In dynamic mode, on a cycle with both `shift_en_i` and `pat_start_i` low, `part_active_o` holds.
- R8: While `shift_en_i` is low, `chain_si_o` holds its last value.
- R9: A shift cycle's mapped pin values appear on `chain_si_o` one clock after the edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_pin_i | input | 4 | External scan-in pins |
| shift_en_i | input | 1 | Shift enable; chains load when high |
| pat_start_i | input | 1 | Pattern-start strobe |
| cfg_sel_i | input | 1 | Requested partition (0 = A, 1 = B) |
| dyn_mode_i | input | 1 | Switching policy: 0 static, 1 dynamic |
| chain_si_o | output | 8 | Registered scan-in bits for the internal chains |
| part_active_o | output | 1 | Partition in force |

## Verification
The bench toggles the select in the middle of a static pattern. A design that ignores the pattern boundary would change the reported partition and remap the chains at once. The bench also drives a strobe and a shift in the same cycle. A design that delays the new partition by one cycle would load that first shift through the old map. In partition B the bench toggles pin 3 alone, which exposes any leftover path from that pin. In dynamic mode the bench changes the select while shift is idle, and a design that tracked the select at all times would update the reported partition there.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int BSD_PINS   = 4;
  localparam int BSD_CHAINS = 8;
  localparam int BSD_PIN_W  = 2;

  typedef enum logic {PART_A = 1'b0, PART_B = 1'b1} part_e;

  // Two-bit pin index per chain, chain 0 in the low bits.
  localparam logic [BSD_CHAINS*BSD_PIN_W-1:0] PART_A_MAP = 16'b10_01_00_10_11_00_00_11;
  localparam logic [BSD_CHAINS*BSD_PIN_W-1:0] PART_B_MAP = 16'b10_10_00_10_01_10_01_00;

  function automatic logic [BSD_PIN_W-1:0] part_pin(part_e p, int unsigned chain);
    if (p == PART_B) return PART_B_MAP[chain*BSD_PIN_W +: BSD_PIN_W];
    return PART_A_MAP[chain*BSD_PIN_W +: BSD_PIN_W];
  endfunction
endpackage

// File: rtl/bsd_cfg_ctrl.sv
module bsd_cfg_ctrl
  import bsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dyn_mode,
  input  logic  shift_en,
  input  logic  pat_start,
  input  logic  cfg_sel,
  output part_e part_eff,
  output part_e part_active
);
  logic  dyn_window;
  logic  take_req;
  part_e part_q;

  assign dyn_window = shift_en | pat_start;
  assign take_req   = dyn_mode ? dyn_window : pat_start;
  assign part_eff   = take_req ? part_e'(cfg_sel) : part_q;
  assign part_active = part_q;

  always_ff @(posedge clk) begin
    if (!rst_n) part_q <= PART_A;
    else        part_q <= part_eff;
  end

  a_r4_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_mode && !pat_start) |=> $stable(part_active));
  a_r5_static_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_mode && pat_start) |=> (part_active == part_e'($past(cfg_sel))));
  a_r6_dyn_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode && shift_en) |=> (part_active == part_e'($past(cfg_sel))));
  a_r7_dyn_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode && !shift_en && !pat_start) |=> $stable(part_active));
endmodule

// File: rtl/bsd_chain_slice.sv
module bsd_chain_slice
  import bsd_pkg::*;
#(
  parameter int NUM_PINS  = BSD_PINS,
  parameter int CHAIN_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [NUM_PINS-1:0] pins,
  input  part_e               part_eff,
  output logic                chain_bit
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [PIN_W-1:0] src_idx;
  logic             src_bit;
  logic             bit_q;

  assign src_idx   = PIN_W'(part_pin(part_eff, CHAIN_IDX));
  assign src_bit   = pins[src_idx];
  assign chain_bit = bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        bit_q <= 1'b0;
    else if (shift_en) bit_q <= src_bit;
  end

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_bit));
endmodule

// File: rtl/bscan_fanout_top.sv
module bscan_fanout_top
  import bsd_pkg::*;
#(
  parameter int NUM_PINS   = BSD_PINS,
  parameter int NUM_CHAINS = BSD_CHAINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   scan_pin_i,
  input  logic                  shift_en_i,
  input  logic                  pat_start_i,
  input  logic                  cfg_sel_i,
  input  logic                  dyn_mode_i,
  output logic [NUM_CHAINS-1:0] chain_si_o,
  output logic                  part_active_o
);
  part_e part_eff;
  part_e part_active;

  bsd_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dyn_mode   (dyn_mode_i),
    .shift_en   (shift_en_i),
    .pat_start  (pat_start_i),
    .cfg_sel    (cfg_sel_i),
    .part_eff   (part_eff),
    .part_active(part_active)
  );

  assign part_active_o = part_active;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    bsd_chain_slice #(.NUM_PINS(NUM_PINS), .CHAIN_IDX(c)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en_i),
      .pins     (scan_pin_i),
      .part_eff (part_eff),
      .chain_bit(chain_si_o[c])
    );
  end

  // R3: under partition B no chain depends on pin 3.
  a_r3_pin3_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && part_eff == PART_B) |=>
      ((chain_si_o[0] == $past(scan_pin_i[0])) && (chain_si_o[2] == $past(scan_pin_i[2]))));
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (chain_si_o == '0 && part_active_o == 1'b0));
endmodule

// File: tb/test_bscan_fanout_top.sv
module test_bscan_fanout_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = '0;
  logic       sh = 1'b0, ps = 1'b0, sel = 1'b0, dyn = 1'b0;
  logic [7:0] chain_o;
  logic       act_o;

  int checks = 0;
  int fails  = 0;

  bscan_fanout_top i_bscan_fanout_top (
    .clk(clk), .rst_n(rst_n), .scan_pin_i(pins), .shift_en_i(sh),
    .pat_start_i(ps), .cfg_sel_i(sel), .dyn_mode_i(dyn),
    .chain_si_o(chain_o), .part_active_o(act_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: chain numbers are 0-based; returns source pin.
  function automatic int ref_pin(int cfg, int ch);
    if (cfg == 0) begin
      if (ch inside {1, 2, 5}) return 0;
      if (ch == 6)             return 1;
      if (ch inside {4, 7})    return 2;
      return 3;
    end
    if (ch inside {0, 5})       return 0;
    if (ch inside {1, 3})       return 1;
    return 2;
  endfunction

  int         m_act = 0;
  logic [7:0] m_chain = '0;

  always @(posedge clk) begin
    int eff;
    if (!rst_n) begin
      m_act = 0;
      m_chain = '0;
    end else begin
      eff = m_act;
      if (dyn ? (sh || ps) : ps) eff = int'(sel);
      if (sh) for (int c = 0; c < 8; c++) m_chain[c] = pins[ref_pin(eff, c)];
      m_act = eff;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle compare against model, at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(chain_o == m_chain, "R2 R3 R8 R9 chain map", chain_o, m_chain);
      check(int'(act_o) == m_act, "R4 R5 R6 R7 active part", act_o, m_act);
    end
  end

  task automatic drive(logic [3:0] p, logic s, logic st, logic cs, logic d);
    @(negedge clk);
    pins = p; sh = s; ps = st; sel = cs; dyn = d;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(chain_o == 8'h00, "R1 reset chains", chain_o, 0);
    check(act_o == 1'b0, "R1 reset part", act_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(chain_o == 8'h00 && act_o == 1'b0, "R1 after reset", {act_o, chain_o}, 0);

    // R2: partition A, pin 3 alone -> chains 0 and 3
    drive(4'b1000, 1, 0, 0, 0);
    drive(4'b0000, 0, 0, 0, 0);
    check(chain_o == 8'b0000_1001, "R2 pin3 under A", chain_o, 8'b0000_1001);
    drive(4'b0001, 1, 0, 0, 0);
    drive(4'b0000, 0, 0, 0, 0);
    check(chain_o == 8'b0010_0110, "R2 pin0 under A", chain_o, 8'b0010_0110);
    // R8: idle keeps value
    drive(4'b1111, 0, 0, 0, 0);
    drive(4'b1111, 0, 0, 0, 0);
    check(chain_o == 8'b0010_0110, "R8 hold while idle", chain_o, 8'b0010_0110);

    // R4: static, select B mid-pattern, no strobe
    drive(4'b0100, 1, 0, 1, 0);
    drive(4'b0100, 1, 0, 1, 0);
    check(act_o == 1'b0, "R4 static pending", act_o, 0);
    check(chain_o == 8'b1001_0000, "R4 still map A", chain_o, 8'b1001_0000);

    // R5: strobe with shift applies B in that cycle
    drive(4'b0100, 1, 1, 1, 0);
    drive(4'b0000, 0, 0, 1, 0);
    check(act_o == 1'b1, "R5 strobe applies", act_o, 1);
    check(chain_o == 8'b1101_0100, "R5 strobe cycle uses B", chain_o, 8'b1101_0100);

    // R3: pin 3 toggled alone under B
    drive(4'b0000, 1, 0, 1, 0);
    drive(4'b1000, 1, 0, 1, 0);
    drive(4'b0000, 0, 0, 1, 0);
    check(chain_o == 8'h00, "R3 pin3 unused under B", chain_o, 0);

    // R6/R7: dynamic mode
    drive(4'b1000, 0, 0, 0, 1);
    drive(4'b1000, 0, 0, 0, 1);
    check(act_o == 1'b1, "R7 dynamic idle hold", act_o, 1);
    drive(4'b1000, 1, 0, 0, 1);
    drive(4'b0000, 0, 0, 0, 1);
    check(act_o == 1'b0, "R6 dynamic switch", act_o, 0);
    check(chain_o == 8'b0000_1001, "R6 switch cycle uses A", chain_o, 8'b0000_1001);

    // Random traffic, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      drive(4'($urandom), 1'($urandom), ($urandom % 8) == 0, 1'($urandom),
            (i / 150) % 2 == 1);
    end
    drive(4'b0000, 0, 0, 0, 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule